// File: doc/BRIEF.md
# Dual-Channel GPIO Register Core

This block is a memory-mapped general-purpose I/O core. It has one or two channels of equal, parameterised width. Each channel holds a data register and a direction register. A single-cycle register port reaches both registers and qualifies writes with byte enables. For every channel the core drives a dedicated output-data bus and a tri-enable bus. It also drives the output half of a pad pair: an output value and an active-high output enable, for an external bidirectional buffer.

A parameter per channel selects where input values come from: the pad's input leg or a separate bus of input-only pins. Reading a data register merges the two sources bit by bit. Input bits return the live pin value and output bits return the stored register bit. A second parameter per channel makes the channel input-only. Its direction register is then removed and its output-side signals are tied inactive. The register port returns read data one cycle after the request.

Top module: `gpio_regcore`

## Requirements
- R1: After reset each implemented data register holds its per-channel reset parameter (default all zeros) and each direction register holds its reset parameter (default all ones, every pin an input). `regRdata` reads 0 and every pad output enable is low.
- R2: A direction bit of 1 makes the pin an input, with its pad output enable low. A direction bit of 0 makes it an output, with its pad output enable high. The direction register appears on the channel's tri-enable output.
- R3: A data-register write updates the stored value, which appears on both the output-data bus and the pad output value in the cycle after the write.
- R4: Write byte enables act per byte: register bit i changes only when `regByteEn[i/8]` is 1. A write with all byte enables clear changes nothing.
- R5: A data-register read returns the sampled pin value for bits whose direction bit is 1, and the stored data bit for bits whose direction bit is 0.
- R6: Read data appears on `regRdata` in the cycle after a read request. In every cycle that does not follow a read request it is zero.
- R7: A channel whose pad-source parameter is 1 samples its pad input leg. With the parameter at 0 it samples its dedicated input-only pins.
- R8: In an input-only channel the output-data, tri-enable, pad output value and pad output enable are all 0. Its direction register reads 0 and ignores writes, and its data register reads return the pins.
- R9: With the dual-channel parameter at 0, channel 2 outputs are all 0, its registers read 0 and writes to them are ignored.
- R10: Register word offsets are 0x0 for channel 1 data, 0x4 for channel 1 direction, 0x8 for channel 2 data and 0xC for channel 2 direction. Any other address, including unaligned ones and those with upper address bits set, reads 0 and ignores writes.
- R11: A data write to a bit configured as input is stored. The stored bit becomes the read and pad value once that bit is switched to output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 1 | Register access request this cycle |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | ADDR_W | Byte address of the register |
| regByteEn | input | 4 | Write byte enables |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, one cycle after the request |
| ch1PadIn | input | WIDTH | Channel 1 pad input leg |
| ch1In | input | WIDTH | Channel 1 dedicated input pins |
| ch1DataOut | output | WIDTH | Channel 1 data register output |
| ch1TriOut | output | WIDTH | Channel 1 direction register output (1 = input) |
| ch1PadOut | output | WIDTH | Channel 1 pad output value |
| ch1PadOe | output | WIDTH | Channel 1 pad output enable (1 = drive) |
| ch2PadIn | input | WIDTH | Channel 2 pad input leg |
| ch2In | input | WIDTH | Channel 2 dedicated input pins |
| ch2DataOut | output | WIDTH | Channel 2 data register output |
| ch2TriOut | output | WIDTH | Channel 2 direction register output (1 = input) |
| ch2PadOut | output | WIDTH | Channel 2 pad output value |
| ch2PadOe | output | WIDTH | Channel 2 pad output enable (1 = drive) |

## Verification
The hardest case to reach from the ports is a read that shows a stored data bit which was written while that bit was still an input. The value has no effect on any pin until a later direction write. The stimulus writes a data byte over input bits and checks that the read still returns the pins. It then clears the direction bits and checks that the earlier value appears. A second instance with channel 1 input-only and channel 2 absent shares the same bus stimulus. This shows that writes aimed at removed registers leave every output and read result at zero. Channel 2 of the main instance drives its pad inputs with the complement of its dedicated pins, so the merged read shows which source is used.

// File: rtl/gpio_regcore_pkg.sv
package gpio_regcore_pkg;
  localparam int BUS_W = 32;
  localparam int BE_W  = BUS_W / 8;

  typedef enum logic [1:0] {
    SLOT_DATA1 = 2'd0,
    SLOT_DIR1  = 2'd1,
    SLOT_DATA2 = 2'd2,
    SLOT_DIR2  = 2'd3
  } regSlot_e;

  typedef struct packed {
    logic [1:0] dataWe;
    logic [1:0] dirWe;
    logic       rdEn;
    logic       rdHit;
    regSlot_e   rdSlot;
  } strobes_t;
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_regcore_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter bit DUAL     = 1'b1,
  parameter bit IN_ONLY1 = 1'b0,
  parameter bit IN_ONLY2 = 1'b0
) (
  input  logic              regSel,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  output strobes_t          strb
);
  logic     upperZero;
  logic     aligned;
  logic     present;
  logic     hit;
  logic     doWrite;
  regSlot_e slot;

  if (ADDR_W > 4) begin : g_upper
    assign upperZero = ~|regAddr[ADDR_W-1:4];
  end else begin : g_noupper
    assign upperZero = 1'b1;
  end

  assign aligned = ~|regAddr[1:0];
  assign slot    = regSlot_e'(regAddr[3:2]);

  always_comb begin
    unique case (slot)
      SLOT_DATA1: present = 1'b1;
      SLOT_DIR1:  present = !IN_ONLY1;
      SLOT_DATA2: present = DUAL;
      SLOT_DIR2:  present = DUAL && !IN_ONLY2;
      default:    present = 1'b0;
    endcase
  end

  assign hit     = upperZero && aligned && present;
  assign doWrite = regSel && regWrite && hit;

  always_comb begin
    strb           = '0;
    strb.dataWe[0] = doWrite && (slot == SLOT_DATA1);
    strb.dirWe[0]  = doWrite && (slot == SLOT_DIR1);
    strb.dataWe[1] = doWrite && (slot == SLOT_DATA2);
    strb.dirWe[1]  = doWrite && (slot == SLOT_DIR2);
    strb.rdEn      = regSel && !regWrite;
    strb.rdHit     = hit;
    strb.rdSlot    = slot;
  end
endmodule

// File: rtl/gpio_chan.sv
module gpio_chan #(
  parameter int             W        = 32,
  parameter bit             IN_ONLY  = 1'b0,
  parameter bit             PAD_SRC  = 1'b1,
  parameter logic [W-1:0]   DATA_RST = '0,
  parameter logic [W-1:0]   DIR_RST  = '1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         dataWe,
  input  logic         dirWe,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] wmask,
  input  logic [W-1:0] padIn,
  input  logic [W-1:0] pinIn,
  output logic [W-1:0] dataOut,
  output logic [W-1:0] triOut,
  output logic [W-1:0] padOut,
  output logic [W-1:0] padOe,
  output logic [W-1:0] rdData,
  output logic [W-1:0] rdDir
);
  logic [W-1:0] pinVal;

  if (PAD_SRC) begin : g_pad
    assign pinVal = padIn;
  end else begin : g_ded
    assign pinVal = pinIn;
  end

  if (IN_ONLY) begin : g_inonly
    assign dataOut = '0;
    assign triOut  = '0;
    assign padOut  = '0;
    assign padOe   = '0;
    assign rdData  = pinVal;
    assign rdDir   = '0;
  end else begin : g_io
    logic [W-1:0] dataQ;
    logic [W-1:0] dirQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dataQ <= DATA_RST;
      end else if (dataWe) begin
        dataQ <= (dataQ & ~wmask) | (wdata & wmask);
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dirQ <= DIR_RST;
      end else if (dirWe) begin
        dirQ <= (dirQ & ~wmask) | (wdata & wmask);
      end
    end

    assign dataOut = dataQ;
    assign triOut  = dirQ;
    assign padOut  = dataQ;
    assign padOe   = ~dirQ;
    assign rdData  = (dirQ & pinVal) | (~dirQ & dataQ);
    assign rdDir   = dirQ;
  end
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_regcore_pkg::*;
#(
  parameter int               WIDTH     = 32,
  parameter bit               DUAL      = 1'b1,
  parameter bit               IN_ONLY1  = 1'b0,
  parameter bit               IN_ONLY2  = 1'b0,
  parameter bit               PAD_SRC1  = 1'b1,
  parameter bit               PAD_SRC2  = 1'b1,
  parameter logic [WIDTH-1:0] DATA_RST1 = '0,
  parameter logic [WIDTH-1:0] DIR_RST1  = '1,
  parameter logic [WIDTH-1:0] DATA_RST2 = '0,
  parameter logic [WIDTH-1:0] DIR_RST2  = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strb,
  input  logic [BE_W-1:0]  regByteEn,
  input  logic [BUS_W-1:0] regWdata,
  output logic [BUS_W-1:0] regRdata,
  input  logic [WIDTH-1:0] ch1PadIn,
  input  logic [WIDTH-1:0] ch1In,
  output logic [WIDTH-1:0] ch1DataOut,
  output logic [WIDTH-1:0] ch1TriOut,
  output logic [WIDTH-1:0] ch1PadOut,
  output logic [WIDTH-1:0] ch1PadOe,
  input  logic [WIDTH-1:0] ch2PadIn,
  input  logic [WIDTH-1:0] ch2In,
  output logic [WIDTH-1:0] ch2DataOut,
  output logic [WIDTH-1:0] ch2TriOut,
  output logic [WIDTH-1:0] ch2PadOut,
  output logic [WIDTH-1:0] ch2PadOe
);
  logic [WIDTH-1:0] wmask;
  logic [WIDTH-1:0] wval;
  logic [WIDTH-1:0] rdData1, rdDir1, rdData2, rdDir2;
  logic [WIDTH-1:0] rdNext;
  logic [BUS_W-1:0] rdataQ;

  for (genvar i = 0; i < WIDTH; i++) begin : g_mask
    assign wmask[i] = regByteEn[i / 8];
  end
  assign wval = regWdata[WIDTH-1:0];

  gpio_chan #(
    .W(WIDTH), .IN_ONLY(IN_ONLY1), .PAD_SRC(PAD_SRC1),
    .DATA_RST(DATA_RST1), .DIR_RST(DIR_RST1)
  ) u_ch1 (
    .clk(clk), .rstN(rstN),
    .dataWe(strb.dataWe[0]), .dirWe(strb.dirWe[0]),
    .wdata(wval), .wmask(wmask),
    .padIn(ch1PadIn), .pinIn(ch1In),
    .dataOut(ch1DataOut), .triOut(ch1TriOut),
    .padOut(ch1PadOut), .padOe(ch1PadOe),
    .rdData(rdData1), .rdDir(rdDir1)
  );

  if (DUAL) begin : g_ch2
    gpio_chan #(
      .W(WIDTH), .IN_ONLY(IN_ONLY2), .PAD_SRC(PAD_SRC2),
      .DATA_RST(DATA_RST2), .DIR_RST(DIR_RST2)
    ) u_ch2 (
      .clk(clk), .rstN(rstN),
      .dataWe(strb.dataWe[1]), .dirWe(strb.dirWe[1]),
      .wdata(wval), .wmask(wmask),
      .padIn(ch2PadIn), .pinIn(ch2In),
      .dataOut(ch2DataOut), .triOut(ch2TriOut),
      .padOut(ch2PadOut), .padOe(ch2PadOe),
      .rdData(rdData2), .rdDir(rdDir2)
    );
  end else begin : g_noch2
    assign ch2DataOut = '0;
    assign ch2TriOut  = '0;
    assign ch2PadOut  = '0;
    assign ch2PadOe   = '0;
    assign rdData2    = '0;
    assign rdDir2     = '0;
  end

  always_comb begin
    unique case (strb.rdSlot)
      SLOT_DATA1: rdNext = rdData1;
      SLOT_DIR1:  rdNext = rdDir1;
      SLOT_DATA2: rdNext = rdData2;
      SLOT_DIR2:  rdNext = rdDir2;
      default:    rdNext = '0;
    endcase
    if (!strb.rdHit) rdNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataQ <= '0;
    end else if (strb.rdEn) begin
      rdataQ <= BUS_W'(rdNext);
    end else begin
      rdataQ <= '0;
    end
  end

  assign regRdata = rdataQ;
endmodule

// File: rtl/gpio_regcore.sv
module gpio_regcore
  import gpio_regcore_pkg::*;
#(
  parameter int               WIDTH          = 32,
  parameter int               ADDR_W         = 8,
  parameter bit               DUAL           = 1'b1,
  parameter bit               CH1_INPUT_ONLY = 1'b0,
  parameter bit               CH2_INPUT_ONLY = 1'b0,
  parameter bit               CH1_PAD_SRC    = 1'b1,
  parameter bit               CH2_PAD_SRC    = 1'b1,
  parameter logic [WIDTH-1:0] CH1_DATA_RST   = '0,
  parameter logic [WIDTH-1:0] CH1_DIR_RST    = '1,
  parameter logic [WIDTH-1:0] CH2_DATA_RST   = '0,
  parameter logic [WIDTH-1:0] CH2_DIR_RST    = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [3:0]        regByteEn,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [WIDTH-1:0]  ch1PadIn,
  input  logic [WIDTH-1:0]  ch1In,
  output logic [WIDTH-1:0]  ch1DataOut,
  output logic [WIDTH-1:0]  ch1TriOut,
  output logic [WIDTH-1:0]  ch1PadOut,
  output logic [WIDTH-1:0]  ch1PadOe,
  input  logic [WIDTH-1:0]  ch2PadIn,
  input  logic [WIDTH-1:0]  ch2In,
  output logic [WIDTH-1:0]  ch2DataOut,
  output logic [WIDTH-1:0]  ch2TriOut,
  output logic [WIDTH-1:0]  ch2PadOut,
  output logic [WIDTH-1:0]  ch2PadOe
);
  strobes_t strb;

  gpio_ctrl #(
    .ADDR_W(ADDR_W), .DUAL(DUAL),
    .IN_ONLY1(CH1_INPUT_ONLY), .IN_ONLY2(CH2_INPUT_ONLY)
  ) u_ctrl (
    .regSel(regSel), .regWrite(regWrite), .regAddr(regAddr), .strb(strb)
  );

  gpio_datapath #(
    .WIDTH(WIDTH), .DUAL(DUAL),
    .IN_ONLY1(CH1_INPUT_ONLY), .IN_ONLY2(CH2_INPUT_ONLY),
    .PAD_SRC1(CH1_PAD_SRC), .PAD_SRC2(CH2_PAD_SRC),
    .DATA_RST1(CH1_DATA_RST), .DIR_RST1(CH1_DIR_RST),
    .DATA_RST2(CH2_DATA_RST), .DIR_RST2(CH2_DIR_RST)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .regByteEn(regByteEn), .regWdata(regWdata), .regRdata(regRdata),
    .ch1PadIn(ch1PadIn), .ch1In(ch1In),
    .ch1DataOut(ch1DataOut), .ch1TriOut(ch1TriOut),
    .ch1PadOut(ch1PadOut), .ch1PadOe(ch1PadOe),
    .ch2PadIn(ch2PadIn), .ch2In(ch2In),
    .ch2DataOut(ch2DataOut), .ch2TriOut(ch2TriOut),
    .ch2PadOut(ch2PadOut), .ch2PadOe(ch2PadOe)
  );
endmodule

// File: rtl/gpio_regcore_chk.sv
module gpio_regcore_chk #(
  parameter int WIDTH    = 32,
  parameter int ADDR_W   = 8,
  parameter bit DUAL     = 1'b1,
  parameter bit IN_ONLY1 = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic              regSel,
  input logic              regWrite,
  input logic [ADDR_W-1:0] regAddr,
  input logic [3:0]        regByteEn,
  input logic [31:0]       regWdata,
  input logic [31:0]       regRdata,
  input logic [WIDTH-1:0]  ch1DataOut,
  input logic [WIDTH-1:0]  ch1TriOut,
  input logic [WIDTH-1:0]  ch2DataOut,
  input logic [WIDTH-1:0]  ch2TriOut
);
  logic wrAt0, wrAt4, wrAt8, wrAtC;
  assign wrAt0 = regSel && regWrite && (regAddr == ADDR_W'(0));
  assign wrAt4 = regSel && regWrite && (regAddr == ADDR_W'(4));
  assign wrAt8 = regSel && regWrite && (regAddr == ADDR_W'(8));
  assign wrAtC = regSel && regWrite && (regAddr == ADDR_W'(12));

  // R6: no read request means zero read data next cycle
  p_idle_rdata_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(regSel && !regWrite) |=> (regRdata == '0));

  // R3: channel 1 data output changes only through a write at offset 0x0
  p_data1_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !wrAt0 |=> $stable(ch1DataOut));

  // R2: channel 1 direction changes only through a write at offset 0x4
  p_dir1_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !wrAt4 |=> $stable(ch1TriOut));

  if (!IN_ONLY1 && WIDTH >= 8) begin : g_land
    // R4: an enabled low byte lands in the data output
    p_byte_lands_r4: assert property (@(posedge clk) disable iff (!rstN)
      (wrAt0 && regByteEn[0]) |=> (ch1DataOut[7:0] == $past(regWdata[7:0])));
  end else begin : g_inonly
    // R8: input-only channel keeps its output side at zero
    p_inonly_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
      (ch1DataOut == '0) && (ch1TriOut == '0));
  end

  if (DUAL) begin : g_dual
    // R10: channel 2 registers change only at their own offsets
    p_data2_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
      !wrAt8 |=> $stable(ch2DataOut));
    p_dir2_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
      !wrAtC |=> $stable(ch2TriOut));
  end else begin : g_single
    // R9: absent channel 2 stays quiet
    p_ch2_absent_r9: assert property (@(posedge clk) disable iff (!rstN)
      (ch2DataOut == '0) && (ch2TriOut == '0));
  end
endmodule

bind gpio_regcore gpio_regcore_chk #(
  .WIDTH(WIDTH), .ADDR_W(ADDR_W), .DUAL(DUAL), .IN_ONLY1(CH1_INPUT_ONLY)
) u_chk (.*);

// File: tb/gpio_regcore_test.sv
module gpio_regcore_test;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 16;
  localparam int AW = 8;

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic [15:0] pad1;
    logic [15:0] in2;
    logic [31:0] exp;
  } vec_t;

  // Walked in order; expected read values follow R5/R7/R10 by hand.
  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h04, 4'h0, 32'h0,         16'h0000, 16'h0000, 32'h0000FFFF}, // R1 R10 dir reset
    '{1'b1, 8'h04, 4'h1, 32'h0,         16'h0000, 16'h0000, 32'h0},        // low byte -> outputs
    '{1'b1, 8'h00, 4'h3, 32'h0000A55A,  16'h0000, 16'h0000, 32'h0},
    '{1'b0, 8'h00, 4'h0, 32'h0,         16'h3C00, 16'h0000, 32'h00003C5A}, // R5 merge
    '{1'b1, 8'h0C, 4'h2, 32'h0,         16'h0000, 16'h0000, 32'h0},        // ch2 dir = 00FF
    '{1'b1, 8'h08, 4'h3, 32'h00001234,  16'h0000, 16'h0000, 32'h0},
    '{1'b0, 8'h08, 4'h0, 32'h0,         16'h0000, 16'hFFFF, 32'h000012FF}, // R7 dedicated pins
    '{1'b0, 8'h0C, 4'h0, 32'h0,         16'h0000, 16'h0000, 32'h000000FF}, // R4 byte1 only
    '{1'b1, 8'h00, 4'h2, 32'hFFFF0000,  16'h0000, 16'h0000, 32'h0},        // byte1 <- 00
    '{1'b0, 8'h00, 4'h0, 32'h0,         16'h0000, 16'h0000, 32'h0000005A}, // R4
    '{1'b1, 8'h00, 4'h0, 32'hFFFFFFFF,  16'h0000, 16'h0000, 32'h0},        // no byte enables
    '{1'b0, 8'h00, 4'h0, 32'h0,         16'h0000, 16'h0000, 32'h0000005A}, // R4 unchanged
    '{1'b1, 8'h10, 4'hF, 32'h0,         16'h0000, 16'h0000, 32'h0},        // unmapped write
    '{1'b0, 8'h10, 4'h0, 32'h0,         16'h0000, 16'h0000, 32'h0},        // R10 reads zero
    '{1'b0, 8'h00, 4'h0, 32'h0,         16'h0000, 16'h0000, 32'h0000005A}  // R10 no alias
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regSel = 1'b0, regWrite = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [3:0]    regByteEn = '0;
  logic [31:0]   regWdata = '0;
  logic [W-1:0]  ch1PadIn = '0, ch1In = '0, ch2PadIn = '1, ch2In = '0;
  logic [31:0]   rdA, rdB;
  logic [W-1:0]  a1Data, a1Tri, a1Pad, a1Oe, a2Data, a2Tri, a2Pad, a2Oe;
  logic [W-1:0]  b1Data, b1Tri, b1Pad, b1Oe, b2Data, b2Tri, b2Pad, b2Oe;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_regcore #(.WIDTH(W), .ADDR_W(AW), .DUAL(1'b1), .CH2_PAD_SRC(1'b0)) uut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrite(regWrite),
    .regAddr(regAddr), .regByteEn(regByteEn), .regWdata(regWdata), .regRdata(rdA),
    .ch1PadIn(ch1PadIn), .ch1In(ch1In), .ch1DataOut(a1Data), .ch1TriOut(a1Tri),
    .ch1PadOut(a1Pad), .ch1PadOe(a1Oe),
    .ch2PadIn(ch2PadIn), .ch2In(ch2In), .ch2DataOut(a2Data), .ch2TriOut(a2Tri),
    .ch2PadOut(a2Pad), .ch2PadOe(a2Oe));

  gpio_regcore #(.WIDTH(W), .ADDR_W(AW), .DUAL(1'b0), .CH1_INPUT_ONLY(1'b1)) uutIn (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrite(regWrite),
    .regAddr(regAddr), .regByteEn(regByteEn), .regWdata(regWdata), .regRdata(rdB),
    .ch1PadIn(ch1PadIn), .ch1In(ch1In), .ch1DataOut(b1Data), .ch1TriOut(b1Tri),
    .ch1PadOut(b1Pad), .ch1PadOe(b1Oe),
    .ch2PadIn(ch2PadIn), .ch2In(ch2In), .ch2DataOut(b2Data), .ch2TriOut(b2Tri),
    .ch2PadOut(b2Pad), .ch2PadOe(b2Oe));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one access at a falling edge; results are sampled at the next falling edge.
  task automatic access(input logic wr, input logic [7:0] addr, input logic [3:0] be,
                        input logic [31:0] wd);
    @(negedge clk);
    regSel = 1'b1; regWrite = wr; regAddr = addr; regByteEn = be; regWdata = wd;
    @(negedge clk);
    regSel = 1'b0; regWrite = 1'b0; regByteEn = '0; regWdata = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 ch1 data", 32'(a1Data), 32'h0);
    check("R1 ch1 dir",  32'(a1Tri),  32'hFFFF);
    check("R1 ch1 oe",   32'(a1Oe),   32'h0);
    check("R1 ch2 dir",  32'(a2Tri),  32'hFFFF);
    check("R1 rdata",    rdA,         32'h0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      ch1PadIn = VECS[i].pad1;
      ch2In    = VECS[i].in2;
      ch2PadIn = ~VECS[i].in2;
      access(VECS[i].wr, VECS[i].addr, VECS[i].be, VECS[i].wdata);
      if (!VECS[i].wr) check($sformatf("R5/R7/R10 vector %0d", i), rdA, VECS[i].exp);
    end

    // R2/R3: pad pins after the table
    check("R3 ch1 dataOut", 32'(a1Data), 32'h005A);
    check("R3 ch1 padOut",  32'(a1Pad),  32'h005A);
    check("R2 ch1 triOut",  32'(a1Tri),  32'hFF00);
    check("R2 ch1 padOe",   32'(a1Oe),   32'h00FF);
    check("R2 ch2 padOe",   32'(a2Oe),   32'hFF00);

    // R6: read data is gone in the idle cycle after a read
    @(negedge clk);
    check("R6 idle rdata", rdA, 32'h0);

    // R11: write over input bits, then turn them to outputs
    ch1PadIn = 16'h0000;
    access(1'b1, 8'h00, 4'h2, 32'h00008100);
    check("R11 stored dataOut", 32'(a1Data), 32'h815A);
    check("R11 oe still low",   32'(a1Oe),   32'h00FF);
    access(1'b0, 8'h00, 4'h0, 32'h0);
    check("R11 read shows pins", rdA, 32'h005A);
    access(1'b1, 8'h04, 4'h3, 32'h0);
    access(1'b0, 8'h00, 4'h0, 32'h0);
    check("R11 read after switch", rdA, 32'h815A);
    check("R11 pad drives", 32'(a1Oe), 32'hFFFF);

    // R8: input-only channel of uutIn
    check("R8 data out low", 32'(b1Data), 32'h0);
    check("R8 tri out low",  32'(b1Tri),  32'h0);
    check("R8 pad oe low",   32'(b1Oe),   32'h0);
    check("R8 pad out low",  32'(b1Pad),  32'h0);
    ch1PadIn = 16'hBEEF;
    access(1'b0, 8'h00, 4'h0, 32'h0);
    check("R8 read returns pins", rdB, 32'h0000BEEF);
    check("R8 uut merged read", rdA, 32'h0000815A);
    access(1'b0, 8'h04, 4'h0, 32'h0);
    check("R8 dir reads zero", rdB, 32'h0);

    // R9: absent channel 2 of uutIn
    access(1'b1, 8'h08, 4'hF, 32'hFFFFFFFF);
    access(1'b1, 8'h0C, 4'hF, 32'h0);
    check("R9 ch2 data low", 32'(b2Data), 32'h0);
    check("R9 ch2 tri low",  32'(b2Tri),  32'h0);
    check("R9 ch2 oe low",   32'(b2Oe),   32'h0);
    access(1'b0, 8'h08, 4'h0, 32'h0);
    check("R9 ch2 reads zero", rdB, 32'h0);

    // R10: unaligned address is unmapped
    access(1'b0, 8'h01, 4'h0, 32'h0);
    check("R10 unaligned read", rdA, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule